// File: doc/BRIEF.md
# Per-Line Edge Interrupt Capture

This block watches a bank of general-purpose I/O lines, 24 with the default parameters, for signal edges and raises one interrupt request when one is caught. Each line has an edge polarity bit and an enable bit. When an enabled line shows a transition in the chosen direction, a sticky per-line capture bit is set. Software reads the capture bits back one byte at a time and acknowledges them by writing a mask. A small summary byte reports which capture bytes hold any set bit, so a handler can go straight to the right byte.

The surrounding register bank does the bus decode and supplies the page number, the byte offset and the write data. Writes on page 1 go to the polarity bytes, on page 2 to the enable bytes and on page 3 to the capture bytes. The pins are asynchronous and are resynchronised inside the block. The request output is a level that stays high while any capture bit is set.

Top module: `edge_irq_capture`

## Requirements
- R1: While rst_n is low at a clock edge, all polarity, enable and capture bits clear. After that edge `irq` is 0 and `pending` is 0.
- R2: A write on page 1 to offset 0x8+b loads polarity byte b, which covers lines 8b to 8b+7 with bit i mapped to line 8b+i. A write on page 2 does the same for enable byte b. A read at the same page and offset returns the stored byte.
- R3: With polarity bit 1 and enable bit 1, a rising level on a line sets its capture bit. The bit is readable at page 3, offset 0x8+b, starting in the third clock edge after the pin changes (two sync stages and one previous-value stage).
- R4: With polarity bit 0 and enable bit 1, a falling level on the line sets its capture bit, with the same latency as R3.
- R5: A line whose enable bit is 0 never sets its capture bit. An edge in the direction opposite to the polarity bit never sets it either.
- R6: A write of value d on page 3 to offset 0x8+b leaves capture byte b as (old & d). Writing 0 clears the whole byte, and bits written as 1 are left unchanged.
- R7: A qualifying edge that lands in the same cycle as a clearing write still sets its capture bit.
- R8: A read at offset 0x6 on any page returns the summary: bit b is 1 when capture byte b is nonzero, and the upper bits are 0. The `pending` output carries the same bits.
- R9: `irq` is high exactly when any capture bit is set. It goes low in the cycle after the write that clears the last set bit.
- R10: Writes on page 0, writes to offsets other than 0x8 to 0x8+NUM_BYTES-1, and cycles with `wr_en` low change no polarity, enable or capture bit. Reads of unmapped page and offset pairs return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| line_in | input | 24 | Asynchronous I/O line levels |
| wr_en | input | 1 | Register write strobe from the bank |
| wr_page | input | 2 | Page selected for the write |
| wr_off | input | 4 | Byte offset of the write |
| wr_data | input | 8 | Write data |
| rd_page | input | 2 | Page selected for the read |
| rd_off | input | 4 | Byte offset of the read |
| rd_data | output | 8 | Combinational read data |
| pending | output | 3 | Per-byte nonzero summary of the capture bits |
| irq | output | 1 | Active-high interrupt request |

## Verification
The hardest case to reach from the ports is an edge that qualifies in exactly the clock in which software clears the same capture byte. Reaching it means counting the two sync stages and the previous-value stage, so that the clearing write is issued two cycles after the pin toggles. The directed part of the stimulus does this on purpose. The random part toggles the lines freely and mixes mask writes onto every page, and a cycle-exact model in the bench catches any further collisions.

// File: rtl/edge_irq_pkg.sv
// Shared page codes and register offsets for the edge interrupt capture unit.
package edge_irq_pkg;
    typedef enum logic [1:0] {
        PG_PORT = 2'd0,
        PG_POL  = 2'd1,
        PG_ENA  = 2'd2,
        PG_CAP  = 2'd3
    } page_e;

    localparam int          BYTE_W     = 8;
    localparam int          OFF_W      = 4;
    localparam logic [3:0]  OFF_SUMM   = 4'h6;
    localparam logic [3:0]  OFF_BANK0  = 4'h8;
endpackage

// File: rtl/edge_sync_detect.sv
// Resynchronises asynchronous line levels through SYNC_STAGES flops, then
// compares the synchronised level with its value one clock earlier.
// Assumes: lines are quasi-static relative to clk; reset drives all stages to 0.
module edge_sync_detect #(
    parameter int WIDTH       = 24,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] level_in,
    output logic [WIDTH-1:0] rise,
    output logic [WIDTH-1:0] fall
);
    logic [WIDTH-1:0] stage_q [SYNC_STAGES];
    logic [WIDTH-1:0] last_q;

    // first synchroniser stage samples the raw pins
    always_ff @(posedge clk) begin
        if (!rst_n) stage_q[0] <= '0;
        else        stage_q[0] <= level_in;
    end

    genvar s;
    generate
        for (s = 1; s < SYNC_STAGES; s++) begin : g_sync
            // further synchroniser stages
            always_ff @(posedge clk) begin
                if (!rst_n) stage_q[s] <= '0;
                else        stage_q[s] <= stage_q[s-1];
            end
        end
    endgenerate

    // hold the previous synchronised level for comparison
    always_ff @(posedge clk) begin
        if (!rst_n) last_q <= '0;
        else        last_q <= stage_q[SYNC_STAGES-1];
    end

    // edge flags from current versus previous level
    always_comb begin
        rise = stage_q[SYNC_STAGES-1] & ~last_q;
        fall = ~stage_q[SYNC_STAGES-1] & last_q;
    end
endmodule

// File: rtl/edge_cfg_regs.sv
// Holds the per-line polarity and enable bytes. One byte register per bank
// byte, loaded when the bank decode selects that byte on the owning page.
// Assumes: byte selects are one-hot or zero.
module edge_cfg_regs #(
    parameter int NUM_BYTES = 3,
    localparam int LINES    = NUM_BYTES * edge_irq_pkg::BYTE_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_BYTES-1:0] pol_sel,
    input  logic [NUM_BYTES-1:0] ena_sel,
    input  logic [7:0]           wdata,
    output logic [LINES-1:0]     pol_q,
    output logic [LINES-1:0]     ena_q
);
    genvar b;
    generate
        for (b = 0; b < NUM_BYTES; b++) begin : g_byte
            // polarity byte b: 1 selects rising, 0 selects falling
            always_ff @(posedge clk) begin
                if (!rst_n)          pol_q[b*8 +: 8] <= '0;
                else if (pol_sel[b]) pol_q[b*8 +: 8] <= wdata;
            end
            // enable byte b: 1 lets the line capture
            always_ff @(posedge clk) begin
                if (!rst_n)          ena_q[b*8 +: 8] <= '0;
                else if (ena_sel[b]) ena_q[b*8 +: 8] <= wdata;
            end
        end
    endgenerate
endmodule

// File: rtl/edge_id_latch.sv
// Sticky capture bits, one per line, grouped into bytes. A mask write keeps
// only bits written as 1; a hit in the same cycle wins over the mask.
// Also forms the per-byte nonzero summary.
// Assumes: clr_sel is one-hot or zero.
module edge_id_latch #(
    parameter int NUM_BYTES = 3,
    localparam int LINES    = NUM_BYTES * edge_irq_pkg::BYTE_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [LINES-1:0]     hit,
    input  logic [NUM_BYTES-1:0] clr_sel,
    input  logic [7:0]           wdata,
    output logic [LINES-1:0]     cap_q,
    output logic [NUM_BYTES-1:0] summ
);
    genvar b;
    generate
        for (b = 0; b < NUM_BYTES; b++) begin : g_byte
            logic [7:0] keep;
            // mask applied only when this byte is written
            always_comb keep = clr_sel[b] ? wdata : 8'hFF;
            // capture update: masked old bits plus new hits
            always_ff @(posedge clk) begin
                if (!rst_n) cap_q[b*8 +: 8] <= '0;
                else        cap_q[b*8 +: 8] <= (cap_q[b*8 +: 8] & keep) | hit[b*8 +: 8];
            end
            // byte nonzero summary
            always_comb summ[b] = |cap_q[b*8 +: 8];
        end
    endgenerate
endmodule

// File: rtl/edge_irq_capture.sv
// Top of the edge interrupt capture unit. Decodes page/offset writes from the
// register bank into byte selects, qualifies edges with polarity and enable,
// and serves combinational reads of all paged bytes and the summary.
// Assumes: the register bank owns page 0 port registers; this block ignores them.
module edge_irq_capture #(
    parameter int NUM_BYTES   = 3,
    parameter int SYNC_STAGES = 2,
    localparam int LINES      = NUM_BYTES * edge_irq_pkg::BYTE_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [LINES-1:0]     line_in,
    input  logic                 wr_en,
    input  logic [1:0]           wr_page,
    input  logic [3:0]           wr_off,
    input  logic [7:0]           wr_data,
    input  logic [1:0]           rd_page,
    input  logic [3:0]           rd_off,
    output logic [7:0]           rd_data,
    output logic [NUM_BYTES-1:0] pending,
    output logic                 irq
);
    import edge_irq_pkg::*;

    logic [LINES-1:0]     rise, fall, hit;
    logic [LINES-1:0]     pol_q, ena_q, cap_q;
    logic [NUM_BYTES-1:0] byte_hit, pol_sel, ena_sel, cap_sel;

    edge_sync_detect #(.WIDTH(LINES), .SYNC_STAGES(SYNC_STAGES)) u_det (
        .clk(clk), .rst_n(rst_n), .level_in(line_in), .rise(rise), .fall(fall)
    );

    // write decode: which bank byte is addressed on which page
    always_comb begin
        for (int b = 0; b < NUM_BYTES; b++) begin
            byte_hit[b] = wr_en && (wr_off == OFF_BANK0 + 4'(b));
            pol_sel[b]  = byte_hit[b] && (wr_page == PG_POL);
            ena_sel[b]  = byte_hit[b] && (wr_page == PG_ENA);
            cap_sel[b]  = byte_hit[b] && (wr_page == PG_CAP);
        end
    end

    edge_cfg_regs #(.NUM_BYTES(NUM_BYTES)) u_cfg (
        .clk(clk), .rst_n(rst_n), .pol_sel(pol_sel), .ena_sel(ena_sel),
        .wdata(wr_data), .pol_q(pol_q), .ena_q(ena_q)
    );

    // qualify edges by polarity and enable
    always_comb hit = ena_q & ((pol_q & rise) | (~pol_q & fall));

    edge_id_latch #(.NUM_BYTES(NUM_BYTES)) u_cap (
        .clk(clk), .rst_n(rst_n), .hit(hit), .clr_sel(cap_sel),
        .wdata(wr_data), .cap_q(cap_q), .summ(pending)
    );

    // request level from the summary
    always_comb irq = |pending;

    // read mux: summary on any page, bank bytes on pages 1 to 3
    always_comb begin
        rd_data = '0;
        if (rd_off == OFF_SUMM) begin
            rd_data[NUM_BYTES-1:0] = pending;
        end else begin
            for (int b = 0; b < NUM_BYTES; b++) begin
                if (rd_off == OFF_BANK0 + 4'(b)) begin
                    case (rd_page)
                        PG_POL:  rd_data = pol_q[b*8 +: 8];
                        PG_ENA:  rd_data = ena_q[b*8 +: 8];
                        PG_CAP:  rd_data = cap_q[b*8 +: 8];
                        default: rd_data = '0;
                    endcase
                end
            end
        end
    end
endmodule

// File: rtl/edge_irq_chk.sv
// Property checker for edge_irq_capture, attached by bind.
module edge_irq_chk #(
    parameter int NUM_BYTES = 3,
    localparam int LINES    = NUM_BYTES * 8
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 irq,
    input logic [NUM_BYTES-1:0] pending,
    input logic [LINES-1:0]     cap_q,
    input logic [LINES-1:0]     ena_q,
    input logic [LINES-1:0]     hit,
    input logic                 wr_en,
    input logic [1:0]           wr_page,
    input logic [3:0]           rd_off,
    input logic [7:0]           rd_data
);
    // R1
    reset_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (cap_q == '0 && ena_q == '0 && !irq));
    // R5
    disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> ((cap_q & ~$past(cap_q) & ~$past(ena_q)) == '0));
    // R7
    hit_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> ((cap_q & $past(hit)) == $past(hit)));
    // R10
    cap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !($past(wr_en) && $past(wr_page) == 2'd3)) |-> (($past(cap_q) & ~cap_q) == '0));
    // R10
    ena_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !($past(wr_en) && $past(wr_page) == 2'd2)) |-> $stable(ena_q));
    // R9
    irq_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq == (cap_q != '0));
    // R8
    summ_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_off == 4'h6) |-> (rd_data == 8'(pending)));
endmodule

bind edge_irq_capture edge_irq_chk #(.NUM_BYTES(NUM_BYTES)) u_chk (
    .clk(clk), .rst_n(rst_n), .irq(irq), .pending(pending), .cap_q(cap_q),
    .ena_q(ena_q), .hit(hit), .wr_en(wr_en), .wr_page(wr_page),
    .rd_off(rd_off), .rd_data(rd_data)
);

// File: tb/sim_edge_irq_capture.sv
module sim_edge_irq_capture;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [23:0] line_in = '0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_page = '0;
    logic [3:0]  wr_off = '0;
    logic [7:0]  wr_data = '0;
    logic [1:0]  rd_page = '0;
    logic [3:0]  rd_off = '0;
    logic [7:0]  rd_data;
    logic [2:0]  pending;
    logic        irq;

    int checks = 0;
    int errors = 0;

    // bench model state
    logic [23:0] m_s1, m_s2, m_prev, m_pol, m_ena, m_cap;

    always #2.5 clk = ~clk;

    edge_irq_capture u0 (
        .clk(clk), .rst_n(rst_n), .line_in(line_in), .wr_en(wr_en),
        .wr_page(wr_page), .wr_off(wr_off), .wr_data(wr_data),
        .rd_page(rd_page), .rd_off(rd_off), .rd_data(rd_data),
        .pending(pending), .irq(irq)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [2:0] m_summ();
        return {|m_cap[23:16], |m_cap[15:8], |m_cap[7:0]};
    endfunction

    function automatic logic [7:0] m_read(input logic [1:0] pg, input logic [3:0] off);
        if (off == 4'h6) return {5'b0, m_summ()};
        if (off >= 4'h8 && off <= 4'hA) begin
            int b = int'(off) - 8;
            case (pg)
                2'd1: return m_pol[b*8 +: 8];
                2'd2: return m_ena[b*8 +: 8];
                2'd3: return m_cap[b*8 +: 8];
                default: return 8'h00;
            endcase
        end
        return 8'h00;
    endfunction

    // one clock: drive at negedge, advance model at posedge, compare at next negedge
    task automatic step(input logic [23:0] lines, input logic we, input logic [1:0] pg,
                        input logic [3:0] off, input logic [7:0] d,
                        input logic [1:0] rpg, input logic [3:0] roff, input string tag);
        logic [23:0] h, keep;
        line_in = lines; wr_en = we; wr_page = pg; wr_off = off; wr_data = d;
        rd_page = rpg; rd_off = roff;
        @(posedge clk);
        h = m_ena & ((m_pol & m_s2 & ~m_prev) | (~m_pol & ~m_s2 & m_prev));
        keep = '1;
        if (we && off >= 4'h8 && off <= 4'hA) begin
            int b = int'(off) - 8;
            if (pg == 2'd3) keep[b*8 +: 8] = d;
            if (pg == 2'd1) m_pol[b*8 +: 8] = d;
            if (pg == 2'd2) m_ena[b*8 +: 8] = d;
        end
        m_cap  = (m_cap & keep) | h;
        m_prev = m_s2; m_s2 = m_s1; m_s1 = lines;
        @(negedge clk);
        check({tag, " irq"}, 32'(irq), 32'(m_cap != '0));
        check({tag, " pending"}, 32'(pending), 32'(m_summ()));
        check({tag, " read"}, 32'(rd_data), 32'(m_read(rpg, roff)));
    endtask

    task automatic idle(input int n, input logic [1:0] rpg, input logic [3:0] roff, input string tag);
        for (int i = 0; i < n; i++) step(line_in, 1'b0, 2'd0, 4'h0, 8'h00, rpg, roff, tag);
    endtask

    initial begin
        m_s1 = '0; m_s2 = '0; m_prev = '0; m_pol = '0; m_ena = '0; m_cap = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state through every mapped byte
        for (int pg = 1; pg < 4; pg++) begin
            for (int off = 8; off < 11; off++) begin
                rd_page = 2'(pg); rd_off = 4'(off); #0.1;
                check("R1 reg after reset", 32'(rd_data), 32'h0);
            end
        end
        check("R1 irq after reset", 32'(irq), 32'h0);
        check("R1 pending after reset", 32'(pending), 32'h0);
        rst_n = 1'b1;

        // R2: polarity and enable readback per byte
        step('0, 1, 2'd1, 4'h8, 8'hA5, 2'd1, 4'h8, "R2");
        check("R2 pol byte0", 32'(rd_data), 32'hA5);
        step('0, 1, 2'd2, 4'hA, 8'h3C, 2'd2, 4'hA, "R2");
        check("R2 ena byte2", 32'(rd_data), 32'h3C);
        // R10: page 0 and unmapped offsets change nothing
        step('0, 1, 2'd0, 4'h8, 8'hFF, 2'd1, 4'h8, "R10");
        check("R10 page0 write", 32'(rd_data), 32'hA5);
        step('0, 1, 2'd2, 4'hB, 8'hFF, 2'd2, 4'hA, "R10");
        check("R10 off 0xB write", 32'(rd_data), 32'h3C);
        step('0, 1, 2'd1, 4'h7, 8'hFF, 2'd0, 4'h9, "R10");
        check("R10 unmapped read", 32'(rd_data), 32'h0);

        // R3: rising edge on line 1, latency of three edges
        step('0, 1, 2'd1, 4'h8, 8'hFF, 2'd3, 4'h8, "R3");
        step('0, 1, 2'd2, 4'h8, 8'hFF, 2'd3, 4'h8, "R3");
        idle(3, 2'd3, 4'h8, "R3");
        step(24'h000002, 0, 2'd0, 4'h0, 8'h0, 2'd3, 4'h8, "R3");
        check("R3 edge+1", 32'(rd_data), 32'h0);
        idle(1, 2'd3, 4'h8, "R3");
        check("R3 edge+2", 32'(rd_data), 32'h0);
        idle(1, 2'd3, 4'h8, "R3");
        check("R3 edge+3 captured", 32'(rd_data), 32'h02);
        check("R9 irq high", 32'(irq), 32'h1);

        // R5: falling edge on a rising-polarity line is ignored
        step(24'h000000, 0, 2'd0, 4'h0, 8'h0, 2'd3, 4'h8, "R5");
        idle(3, 2'd3, 4'h8, "R5");
        check("R5 wrong direction", 32'(rd_data), 32'h02);

        // R6: partial mask keeps bits written as 1, then full clear
        step(24'h000030, 0, 2'd0, 4'h0, 8'h0, 2'd3, 4'h8, "R6");
        idle(3, 2'd3, 4'h8, "R6");
        check("R6 three bits", 32'(rd_data), 32'h32);
        step(line_in, 1, 2'd3, 4'h8, 8'h10, 2'd3, 4'h8, "R6");
        check("R6 masked keep", 32'(rd_data), 32'h10);
        step(line_in, 1, 2'd3, 4'h8, 8'h00, 2'd3, 4'h8, "R9");
        check("R6 zero clears", 32'(rd_data), 32'h0);
        check("R9 irq low next cycle", 32'(irq), 32'h0);

        // R4: falling polarity on byte 1, line 8; R5 disabled line 9
        step(24'h000330, 1, 2'd1, 4'h9, 8'h00, 2'd3, 4'h9, "R4");
        step(24'h000330, 1, 2'd2, 4'h9, 8'h01, 2'd3, 4'h9, "R4");
        idle(4, 2'd3, 4'h9, "R4");
        check("R4 no spurious", 32'(rd_data), 32'h0);
        step(24'h000030, 0, 2'd0, 4'h0, 8'h0, 2'd3, 4'h9, "R4");
        idle(2, 2'd3, 4'h9, "R4");
        check("R4 fall captured, R5 line9 disabled", 32'(rd_data), 32'h01);
        check("R8 summary byte1", 32'(pending), 32'h2);
        step(line_in, 0, 2'd2, 4'h6, 8'h0, 2'd2, 4'h6, "R8");
        check("R8 summary read page2", 32'(rd_data), 32'h02);

        // R7: edge qualifies in the same cycle as the clearing write
        step(24'h000130, 0, 2'd0, 4'h0, 8'h0, 2'd3, 4'h9, "R7");
        step(24'h000030, 0, 2'd0, 4'h0, 8'h0, 2'd3, 4'h9, "R7");
        step(24'h000030, 0, 2'd0, 4'h0, 8'h0, 2'd3, 4'h9, "R7");
        step(24'h000030, 1, 2'd3, 4'h9, 8'h00, 2'd3, 4'h9, "R7");
        check("R7 collision kept", 32'(rd_data), 32'h01);
        step(line_in, 1, 2'd3, 4'h9, 8'h00, 2'd3, 4'h9, "R7");
        check("R7 later clear", 32'(rd_data), 32'h0);

        // random mix against the model
        void'($urandom(32'd1234));
        for (int i = 0; i < 3000; i++) begin
            logic [23:0] ln;
            logic we;
            ln = line_in ^ ($urandom() & $urandom() & $urandom());
            we = ($urandom_range(0, 3) == 0);
            step(ln, we, 2'($urandom_range(0, 3)), 4'($urandom_range(5, 11)),
                 8'($urandom() | ($urandom_range(0, 1) ? 32'hF0 : 32'h0)),
                 2'($urandom_range(0, 3)), 4'($urandom_range(5, 11)), "R3 R4 R6 random");
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule